// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block is the control unit that steers an 8-bit processor core into its reset, non-maskable and maskable interrupt handlers. The core has an accumulator-style register file extended with a third index register and a base-page register. The sequencer watches the two request lines and an instruction-boundary strobe from the execution unit. When an entry is due, it takes over a single-access synchronous memory port. It stores the return context on the stack page and then reads the two-byte handler address. It returns a fresh program counter, status byte and stack pointer to the core, together with a one-cycle completion pulse.

The non-maskable line is edge sensitive. The maskable line is a level that is latched into a pending bit and judged at the next boundary. When the instruction that just finished cleared the interrupt mask, the decision for that boundary uses the live line level. Reset starts a shorter sequence that only reads the vector. On completion it also tells the core to clear its third index and base-page registers.

The state machine has seven states:
- `ST_IDLE` waits for a boundary.
- `ST_PUSH_HI`, `ST_PUSH_LO` and `ST_PUSH_ST` write the context.
- `ST_VEC_LO` and `ST_VEC_HI` read the vector.
- `ST_LOAD` presents the result.

The transitions are:
- `ST_IDLE` goes to `ST_PUSH_HI` on a taken entry.
- The three push states step forward, one per cycle, into `ST_VEC_LO`.
- `ST_VEC_LO` goes to `ST_VEC_HI`, which goes to `ST_LOAD`.
- `ST_LOAD` returns to `ST_IDLE`.
- Reset forces `ST_VEC_LO`, with the entry source set to reset.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset is released, the port reads address 0xFFFC in the first cycle and 0xFFFD in the second. In the third cycle `done` is high and `new_pc` equals {byte at 0xFFFD, byte at 0xFFFC}.
- R2: The status byte holds, from bit 7 down to bit 0, the negative, overflow, extended-mode (bit 5), break (bit 4), decimal (bit 3), interrupt-mask (bit 2), zero (bit 1) and carry flags. At the end of the reset sequence, `new_sp` is 0x01FF, `new_status` is 0x36 (bits 5, 4, 2 and 1 set) and `zb_clear` is high.
- R3: A low-to-high change of `nmi_req` is remembered and entered at the next boundary whatever the mask bit. Keeping the line high does not cause a further entry.
- R4: A high level on `irq_req` sets a pending request. It is entered at a boundary only when bit 2 of `core_status` is 0.
- R5: A pending maskable request is discarded at every boundary, whether or not it is entered. A later boundary with the line low and the mask clear causes no entry.
- R6: In the 1st, 2nd and 3rd cycles after the boundary edge, the port writes PC[15:8] to {0x01, sp}, PC[7:0] to {0x01, sp-1} and `core_status` with bit 4 cleared to {0x01, sp-2}.
- R7: In the 4th and 5th cycles after the boundary edge, the port reads the vector low and high bytes. These are at 0xFFFA/0xFFFB for a non-maskable entry and at 0xFFFE/0xFFFF for a maskable one.
- R8: In the 6th cycle after the boundary edge, `done` is high for one cycle. At that point `new_pc` is the fetched vector and `new_sp` is {0x01, sp-3}. `new_status` is `core_status` with bit 3 cleared and bit 2 set, and `zb_clear` is low.
- R9: When both requests are due at one boundary, the non-maskable entry is taken and the maskable request is discarded.
- R10: At a boundary where `cli_done` is high, the maskable decision uses only the level of `irq_req` in that cycle. An earlier latched pulse is ignored, and an asserted line is entered at that boundary.
- R11: `insn_end` is ignored while `busy` is high, and the port never reads and writes in the same cycle.
- R12: The stack address low byte wraps within page 0x01. With sp = 0x01, the writes go to 0x0101, 0x0100 and 0x01FF, and `new_sp` is 0x01FE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request, edge sensitive |
| irq_req | input | 1 | Maskable request, level sensitive |
| insn_end | input | 1 | Instruction boundary strobe |
| cli_done | input | 1 | The finishing instruction cleared the mask bit |
| core_pc | input | 16 | Return address at the boundary |
| core_status | input | 8 | Status byte at the boundary |
| core_sp | input | 8 | Stack pointer low byte at the boundary |
| mem_addr | output | 16 | Port address |
| mem_wdata | output | 8 | Port write data |
| mem_we | output | 1 | Port write enable |
| mem_re | output | 1 | Port read enable |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 16 | Handler address, valid while done |
| new_status | output | 8 | Status byte for the core, valid while done |
| new_sp | output | 16 | Stack pointer for the core, valid while done |
| zb_clear | output | 1 | Clear third index and base-page registers, valid while done |

## Verification
The bench counts edges from the stimulus. The entry sequence starts at the clock edge that samples `insn_end`: the three stack writes appear in cycles 1 to 3 after it, the vector reads in cycles 4 and 5, and `done` in cycle 6. The reset sequence starts at the deassertion of reset: its two reads fall in cycles 0 and 1 after release and `done` in cycle 2. Every scenario task drives inputs on a falling edge and then checks the port and result outputs at each following falling edge, one expected cycle at a time. A late or early action is therefore reported against the cycle in which it should have appeared. Cases where no entry should occur are checked in the cycle where the first stack write would otherwise show.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_ST,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_LOAD
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_RESET,
        SRC_NMI,
        SRC_IRQ
    } entry_src_t;

    // status byte bit positions, msb first: N V E B D I Z C
    localparam int FLAG_N = 7;
    localparam int FLAG_V = 6;
    localparam int FLAG_E = 5;
    localparam int FLAG_B = 4;
    localparam int FLAG_D = 3;
    localparam int FLAG_I = 2;
    localparam int FLAG_Z = 1;
    localparam int FLAG_C = 0;

endpackage

// File: rtl/intr_req_arbiter.sv
module intr_req_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_line,
    input  logic irq_line,
    input  logic boundary,
    input  logic cli_done,
    input  logic mask_i,
    output logic take_nmi,
    output logic take_irq
);

    logic nmi_seen_q;
    logic nmi_pend_q;
    logic irq_pend_q;
    logic nmi_edge;
    logic nmi_hit;
    logic irq_hit;
    logic irq_pick;

    always_comb begin
        nmi_edge = nmi_line & ~nmi_seen_q;
        nmi_hit  = nmi_pend_q | nmi_edge;
        irq_hit  = irq_pend_q | irq_line;
        // right after the mask was cleared, only the live line counts
        irq_pick = cli_done ? irq_line : irq_hit;
        take_nmi = boundary & nmi_hit;
        take_irq = boundary & ~nmi_hit & irq_pick & ~mask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_seen_q <= 1'b0;
            nmi_pend_q <= 1'b0;
            irq_pend_q <= 1'b0;
        end else begin
            nmi_seen_q <= nmi_line;
            nmi_pend_q <= nmi_hit & ~take_nmi;
            irq_pend_q <= irq_hit & ~boundary;
        end
    end

    // R3: a line held high with nothing remembered cannot start an entry
    a_r3_nmi_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_line && $past(nmi_line) && !nmi_pend_q) |-> !take_nmi);

    // R5: every boundary leaves the maskable request discarded
    a_r5_irq_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !irq_line) |=> !irq_pend_q);

endmodule

// File: rtl/intr_vec_sel.sv
module intr_vec_sel
    import intr_seq_pkg::*;
#(
    parameter int          AW      = 16,
    parameter logic [15:0] NMI_VEC = 16'hFFFA,
    parameter logic [15:0] RST_VEC = 16'hFFFC,
    parameter logic [15:0] IRQ_VEC = 16'hFFFE
) (
    input  entry_src_t    src,
    output logic [AW-1:0] vec_base
);

    always_comb begin
        unique case (src)
            SRC_RESET: vec_base = AW'(RST_VEC);
            SRC_NMI:   vec_base = AW'(NMI_VEC);
            default:   vec_base = AW'(IRQ_VEC);
        endcase
    end

endmodule

// File: rtl/intr_frame_gen.sv
module intr_frame_gen
    import intr_seq_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          DW         = 8,
    parameter logic [7:0]  STACK_PAGE = 8'h01
) (
    input  seq_state_t    state,
    input  logic [AW-1:0] ctx_pc,
    input  logic [DW-1:0] ctx_status,
    input  logic [DW-1:0] ctx_sp,
    input  logic [AW-1:0] vec_base,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_re
);

    localparam int          PW     = AW - DW;
    localparam logic [DW-1:0] B_MASK = DW'(1) << FLAG_B;

    logic [PW-1:0] page;
    logic [DW-1:0] sp_m1;
    logic [DW-1:0] sp_m2;

    always_comb begin
        page  = PW'(STACK_PAGE);
        sp_m1 = ctx_sp - DW'(1);
        sp_m2 = ctx_sp - DW'(2);
    end

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        unique case (state)
            ST_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_addr  = {page, ctx_sp};
                mem_wdata = ctx_pc[AW-1:AW-DW];
            end
            ST_PUSH_LO: begin
                mem_we    = 1'b1;
                mem_addr  = {page, sp_m1};
                mem_wdata = ctx_pc[DW-1:0];
            end
            ST_PUSH_ST: begin
                mem_we    = 1'b1;
                mem_addr  = {page, sp_m2};
                mem_wdata = ctx_status & ~B_MASK;
            end
            ST_VEC_LO: begin
                mem_re   = 1'b1;
                mem_addr = vec_base;
            end
            ST_VEC_HI: begin
                mem_re   = 1'b1;
                mem_addr = vec_base + AW'(1);
            end
            ST_IDLE, ST_LOAD: begin
                mem_we = 1'b0;
                mem_re = 1'b0;
            end
            default: begin
                mem_we = 1'b0;
                mem_re = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_seq_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          DW         = 8,
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [15:0] NMI_VEC    = 16'hFFFA,
    parameter logic [15:0] RST_VEC    = 16'hFFFC,
    parameter logic [15:0] IRQ_VEC    = 16'hFFFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_req,
    input  logic          irq_req,
    input  logic          insn_end,
    input  logic          cli_done,
    input  logic [AW-1:0] core_pc,
    input  logic [DW-1:0] core_status,
    input  logic [DW-1:0] core_sp,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] new_pc,
    output logic [DW-1:0] new_status,
    output logic [AW-1:0] new_sp,
    output logic          zb_clear
);

    localparam int            PW         = AW - DW;
    localparam logic [DW-1:0] D_MASK     = DW'(1) << FLAG_D;
    localparam logic [DW-1:0] I_MASK     = DW'(1) << FLAG_I;
    localparam logic [DW-1:0] RST_STATUS = (DW'(1) << FLAG_E) | (DW'(1) << FLAG_B)
                                         | (DW'(1) << FLAG_I) | (DW'(1) << FLAG_Z);
    localparam int            FRAME_LEN  = 3;

    seq_state_t    state_q;
    seq_state_t    state_d;
    entry_src_t    src_q;
    logic [AW-1:0] ctx_pc_q;
    logic [DW-1:0] ctx_st_q;
    logic [DW-1:0] ctx_sp_q;
    logic [DW-1:0] vec_lo_q;
    logic          boundary;
    logic          take_nmi;
    logic          take_irq;
    logic [AW-1:0] vec_base;

    assign boundary = insn_end & (state_q == ST_IDLE);

    intr_req_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_line (nmi_req),
        .irq_line (irq_req),
        .boundary (boundary),
        .cli_done (cli_done),
        .mask_i   (core_status[FLAG_I]),
        .take_nmi (take_nmi),
        .take_irq (take_irq)
    );

    intr_vec_sel #(
        .AW      (AW),
        .NMI_VEC (NMI_VEC),
        .RST_VEC (RST_VEC),
        .IRQ_VEC (IRQ_VEC)
    ) u_vec (
        .src      (src_q),
        .vec_base (vec_base)
    );

    intr_frame_gen #(
        .AW         (AW),
        .DW         (DW),
        .STACK_PAGE (STACK_PAGE)
    ) u_frame (
        .state      (state_q),
        .ctx_pc     (ctx_pc_q),
        .ctx_status (ctx_st_q),
        .ctx_sp     (ctx_sp_q),
        .vec_base   (vec_base),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_re     (mem_re)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (take_nmi || take_irq) state_d = ST_PUSH_HI;
            ST_PUSH_HI: state_d = ST_PUSH_LO;
            ST_PUSH_LO: state_d = ST_PUSH_ST;
            ST_PUSH_ST: state_d = ST_VEC_LO;
            ST_VEC_LO:  state_d = ST_VEC_HI;
            ST_VEC_HI:  state_d = ST_LOAD;
            ST_LOAD:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and captured context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_VEC_LO;
            src_q    <= SRC_RESET;
            ctx_pc_q <= '0;
            ctx_st_q <= '0;
            ctx_sp_q <= '0;
            vec_lo_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && (take_nmi || take_irq)) begin
                src_q    <= take_nmi ? SRC_NMI : SRC_IRQ;
                ctx_pc_q <= core_pc;
                ctx_st_q <= core_status;
                ctx_sp_q <= core_sp;
            end
            if (state_q == ST_VEC_HI) vec_lo_q <= mem_rdata;
        end
    end

    // result outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_LOAD);
        new_pc   = {mem_rdata, vec_lo_q};
        zb_clear = done & (src_q == SRC_RESET);
        if (src_q == SRC_RESET) begin
            new_status = RST_STATUS;
            new_sp     = {PW'(STACK_PAGE), {DW{1'b1}}};
        end else begin
            new_status = (ctx_st_q & ~D_MASK) | I_MASK;
            new_sp     = {PW'(STACK_PAGE), ctx_sp_q - DW'(FRAME_LEN)};
        end
    end

    // R6: consecutive pushes step the stack address down by one
    a_r6_push_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH_HI) |=> (mem_we && mem_addr == AW'($past(mem_addr) - AW'(1))));

    // R7: the second vector read follows the first at the next address
    a_r7_vec_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VEC_LO) |=> (mem_re && mem_addr == AW'($past(mem_addr) + AW'(1))));

    // R8: the completion pulse lasts one cycle and frees the sequencer
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R11: one access per cycle on the port
    a_r11_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R12: every write lands inside the stack page
    a_r12_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[AW-1:DW] == PW'(STACK_PAGE)));

    // R11: a boundary strobe during a sequence does not restart it
    a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && insn_end && state_q != ST_LOAD) |=> busy);

endmodule

// File: tb/sim_intr_entry_seq.sv
module sim_intr_entry_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        nmi_req;
    logic        irq_req;
    logic        insn_end;
    logic        cli_done;
    logic [15:0] core_pc;
    logic [7:0]  core_status;
    logic [7:0]  core_sp;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_rdata = 8'h00;
    logic        busy;
    logic        done;
    logic [15:0] new_pc;
    logic [7:0]  new_status;
    logic [15:0] new_sp;
    logic        zb_clear;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    intr_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
        .insn_end(insn_end), .cli_done(cli_done), .core_pc(core_pc),
        .core_status(core_status), .core_sp(core_sp), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .new_pc(new_pc),
        .new_status(new_status), .new_sp(new_sp), .zb_clear(zb_clear)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        case (a)
            16'hFFFA: return 8'h11;
            16'hFFFB: return 8'h22;
            16'hFFFC: return 8'h00;
            16'hFFFD: return 8'hC0;
            16'hFFFE: return 8'h34;
            16'hFFFF: return 8'h12;
            default:  return 8'hEE;
        endcase
    endfunction

    always @(posedge clk) if (mem_re) mem_rdata <= mem_byte(mem_addr);

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == WATCHDOG) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL R11 watchdog: actual hung expected finished run");
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reset sequence: reads at release, result two cycles later
    task automatic t_reset();
        rst_n = 1'b0; nmi_req = 1'b0; irq_req = 1'b0; insn_end = 1'b0;
        cli_done = 1'b0; core_pc = 16'h0000; core_status = 8'h00; core_sp = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 first read enable", {31'd0, mem_re}, 32'd1);
        chk("R1 first read address", {16'd0, mem_addr}, 32'hFFFC);
        @(negedge clk);
        chk("R1 second read address", {16'd0, mem_addr}, 32'hFFFD);
        chk("R1 no early done", {31'd0, done}, 32'd0);
        @(negedge clk);
        chk("R1 done at third cycle", {31'd0, done}, 32'd1);
        chk("R1 reset pc", {16'd0, new_pc}, 32'hC000);
        chk("R2 reset sp", {16'd0, new_sp}, 32'h01FF);
        chk("R2 reset status", {24'd0, new_status}, 32'h36);
        chk("R2 zb clear", {31'd0, zb_clear}, 32'd1);
        @(negedge clk);
        chk("R2 idle after reset", {30'd0, done, busy}, 32'd0);
    endtask

    // a boundary at which no entry may start
    task automatic t_quiet(input string tag, input logic [7:0] st, input logic cli);
        @(negedge clk);
        insn_end = 1'b1; core_status = st; cli_done = cli;
        @(negedge clk);
        insn_end = 1'b0; cli_done = 1'b0;
        chk({tag, " no stack write"}, {31'd0, mem_we}, 32'd0);
        chk({tag, " stays idle"}, {31'd0, busy}, 32'd0);
    endtask

    // a boundary at which an entry must start, checked cycle by cycle
    task automatic t_entry(input string tag, input logic is_nmi, input logic cli, input logic hold,
                           input logic [15:0] pc, input logic [7:0] st, input logic [7:0] sp);
        logic [15:0] vec;
        logic [7:0]  spm;
        vec = is_nmi ? 16'hFFFA : 16'hFFFE;
        @(negedge clk);
        insn_end = 1'b1; cli_done = cli; core_pc = pc; core_status = st; core_sp = sp;
        @(negedge clk);
        if (!hold) insn_end = 1'b0;
        cli_done = 1'b0; irq_req = 1'b0;
        chk({tag, " R6 push hi we"}, {31'd0, mem_we}, 32'd1);
        chk({tag, " R6 push hi addr"}, {16'd0, mem_addr}, {16'd0, 8'h01, sp});
        chk({tag, " R6 push hi data"}, {24'd0, mem_wdata}, {24'd0, pc[15:8]});
        @(negedge clk);
        spm = sp - 8'd1;
        chk({tag, " R6 push lo addr"}, {16'd0, mem_addr}, {16'd0, 8'h01, spm});
        chk({tag, " R6 push lo data"}, {24'd0, mem_wdata}, {24'd0, pc[7:0]});
        @(negedge clk);
        spm = sp - 8'd2;
        chk({tag, " R6 push status addr"}, {16'd0, mem_addr}, {16'd0, 8'h01, spm});
        chk({tag, " R6 push status data"}, {24'd0, mem_wdata}, {24'd0, st & 8'hEF});
        @(negedge clk);
        chk({tag, " R7 vec lo read"}, {15'd0, mem_re, mem_addr}, {15'd0, 1'b1, vec});
        chk({tag, " R11 no write on read"}, {31'd0, mem_we}, 32'd0);
        @(negedge clk);
        chk({tag, " R7 vec hi read"}, {15'd0, mem_re, mem_addr}, {15'd0, 1'b1, vec + 16'd1});
        chk({tag, " R8 no early done"}, {31'd0, done}, 32'd0);
        @(negedge clk);
        spm = sp - 8'd3;
        chk({tag, " R8 done"}, {31'd0, done}, 32'd1);
        chk({tag, " R8 new pc"}, {16'd0, new_pc},
            {16'd0, mem_byte(vec + 16'd1), mem_byte(vec)});
        chk({tag, " R8 new status"}, {24'd0, new_status}, {24'd0, (st & 8'hF7) | 8'h04});
        chk({tag, " R8 new sp"}, {16'd0, new_sp}, {16'd0, 8'h01, spm});
        chk({tag, " R8 no zb clear"}, {31'd0, zb_clear}, 32'd0);
        @(negedge clk);
        chk({tag, " R8 done single"}, {30'd0, done, busy}, 32'd0);
        if (hold) begin
            @(negedge clk);
            insn_end = 1'b0;
            chk({tag, " R11 no second entry"}, {30'd0, mem_we, busy}, 32'd0);
        end
    endtask

    task automatic sc_irq_basic();
        @(negedge clk); irq_req = 1'b1;
        t_entry("R4 irq taken", 1'b0, 1'b0, 1'b0, 16'h4567, 8'h30, 8'hF0);
    endtask

    task automatic sc_irq_masked();
        @(negedge clk); irq_req = 1'b1;
        @(negedge clk);
        @(negedge clk); irq_req = 1'b0;
        t_quiet("R4 masked", 8'h24, 1'b0);
        t_quiet("R5 dropped", 8'h20, 1'b0);
    endtask

    task automatic sc_nmi_level();
        @(negedge clk); nmi_req = 1'b1;
        t_entry("R3 nmi edge", 1'b1, 1'b0, 1'b0, 16'h89AB, 8'h3D, 8'h80);
        t_quiet("R3 nmi held", 8'h20, 1'b0);
        nmi_req = 1'b0;
    endtask

    task automatic sc_priority();
        @(negedge clk); nmi_req = 1'b1; irq_req = 1'b1;
        t_entry("R9 nmi first", 1'b1, 1'b0, 1'b0, 16'hA0B0, 8'h20, 8'hC0);
        nmi_req = 1'b0;
        t_quiet("R9 irq discarded", 8'h20, 1'b0);
    endtask

    task automatic sc_cli();
        @(negedge clk); irq_req = 1'b1;
        @(negedge clk); irq_req = 1'b0;
        t_quiet("R10 stale pulse", 8'h20, 1'b1);
        @(negedge clk); irq_req = 1'b1;
        t_entry("R10 live line", 1'b0, 1'b1, 1'b0, 16'h3344, 8'h21, 8'h55);
    endtask

    task automatic sc_wrap();
        @(negedge clk); irq_req = 1'b1;
        t_entry("R12 wrap", 1'b0, 1'b0, 1'b0, 16'h0102, 8'h00, 8'h01);
    endtask

    task automatic sc_busy_hold();
        @(negedge clk); nmi_req = 1'b1;
        t_entry("R11 held strobe", 1'b1, 1'b0, 1'b1, 16'h2233, 8'h24, 8'h10);
        nmi_req = 1'b0;
    endtask

    initial begin
        t_reset();
        sc_irq_basic();
        sc_irq_masked();
        sc_nmi_level();
        sc_priority();
        sc_cli();
        sc_wrap();
        sc_busy_hold();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule